// File: doc/BRIEF.md
# Multiport Pairwise Box Overlap Comparator

This block tests every unordered pair of a set of stored axis-aligned boxes for overlap, several pairs per clock. Each box is held as six single-precision coordinates: the low and high bound on x, y and z. Each coordinate lives in its own memory. That memory is built from `COPIES` identical two-port RAM copies, all written with the same datum at the same address, so it offers `2*COPIES` independent read ports. One read port carries the anchor box. The remaining `2*COPIES-1` ports carry partner boxes. Each cycle, one comparison lane per partner port tests the anchor against that partner.

An internal sequencer walks the address space. At the start of a pass the anchor is box 0 and the partners are the boxes that follow it. While the anchor stays fixed, the partners stride forward by the lane count until the highest valid box has been reached. The anchor then steps by one and the partners restart just after it. Partner addresses beyond the highest box are masked out. A loader writes the box coordinates before a pass starts. A downstream serialiser consumes the lane outputs and the end-of-pass pulse.

Top module: `pair_overlap_cmp`

## Requirements
- R1: A write with `wrEn` high stores all six coordinates at `wrAddr`, and that data is seen identically by the anchor port and every partner port in later passes.
- R2: A pulse on `start` while `busy` is low begins a pass that covers boxes 0..`lastAddr`. `busy` is high from the cycle after `start` is sampled until the cycle of the done pulse. A `start` while busy is ignored and does not change the pass length.
- R3: The first lane group of a pass appears two cycles after `start` is sampled. In that group lane k pairs index_i 0 with index_j k+1.
- R4: While the anchor is unchanged, the lane 0 partner advances by the lane count `2*COPIES-1` each cycle. Once a partner has reached `lastAddr`, the next group has anchor+1 and its lane 0 partner is anchor+2.
- R5: A lane whose partner index exceeds `lastAddr` has `laneValid` low and `laneHit` low. The valid lanes of a group always form a prefix starting at lane 0.
- R6: In one pass each unordered pair (i, j) with i < j <= `lastAddr` appears on a valid lane exactly once, with index_i < index_j. The pass lasts the sum over r = 1..`lastAddr` of ceil(r / lanes) cycles.
- R7: A valid lane reports a hit exactly when, on each of x, y and z, the high bound of box i >= the low bound of box j and the low bound of box i <= the high bound of box j. Touching faces count as overlap.
- R8: Coordinates are IEEE-754 single precision and are ordered as signed real numbers. Negative zero compares equal to positive zero.
- R9: `passDone` is high for exactly one cycle, together with the last lane group of the pass. With `lastAddr` = 0 the pass takes one cycle and shows no valid lane.
- R10: After reset, `laneValid`, `laneHit`, `passDone` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write one box into all memory copies |
| wrAddr | input | AW | Box index being written |
| wrMinX | input | 32 | Low x bound, single precision |
| wrMaxX | input | 32 | High x bound |
| wrMinY | input | 32 | Low y bound |
| wrMaxY | input | 32 | High y bound |
| wrMinZ | input | 32 | Low z bound |
| wrMaxZ | input | 32 | High z bound |
| start | input | 1 | Begin a pass (ignored while busy) |
| lastAddr | input | AW | Highest valid box index for the pass |
| laneValid | output | LANES | Lane carries a real pair |
| laneHit | output | LANES | Pair overlaps |
| laneIdxI | output | LANES*AW | Anchor index per lane |
| laneIdxJ | output | LANES*AW | Partner index per lane |
| passDone | output | 1 | One-cycle end-of-pass pulse |
| busy | output | 1 | A pass is being issued |

## Verification
The bench sweeps every highest-address value of a sixteen-box, three-lane configuration over several coordinate patterns. The riskiest corners are the row switch and the end of the pass. A sequencer that switches rows one step late would emit a duplicate pair. One that switches early, or stops one row short, would drop a pair, and the per-pass coverage matrix and cycle count catch both. Padding lanes past the highest box are checked for silence, since unmasked lanes would report phantom pairs. Touching faces and a negative-zero against positive-zero contact are included, because an exclusive compare or a raw bit-pattern order would miss those hits. A start pulse in the middle of a pass is also applied; a sequencer that restarted on it would lengthen the pass and repeat pairs.

// File: rtl/pbo_pkg.sv
package pbo_pkg;

  localparam int FLT_W = 32;
  localparam int AXES  = 3;

  // control-to-datapath strobes
  typedef struct packed {
    logic issue;   // current addresses form a lane group
    logic finish;  // this group closes the pass
  } seqStrobe_t;

  // map single precision onto an unsigned order; -0 folded onto +0 (R8)
  function automatic logic [FLT_W-1:0] fltKey(input logic [FLT_W-1:0] f);
    logic [FLT_W-1:0] n;
    n = (f == 32'h8000_0000) ? '0 : f;
    return n[FLT_W-1] ? ~n : (n ^ 32'h8000_0000);
  endfunction

  function automatic logic fltGe(input logic [FLT_W-1:0] a, input logic [FLT_W-1:0] b);
    return fltKey(a) >= fltKey(b);
  endfunction

endpackage

// File: rtl/pbo_coord_mem.sv
module pbo_coord_mem #(
  parameter int COPIES = 2,
  parameter int AW     = 4,
  parameter int FW     = 32
) (
  input  logic                      clk,
  input  logic                      wrEn,
  input  logic [AW-1:0]             wrAddr,
  input  logic [FW-1:0]             wrData,
  input  logic [2*COPIES*AW-1:0]    rdAddr,
  output logic [2*COPIES*FW-1:0]    rdData
);
  localparam int DEPTH = 1 << AW;

  // every copy receives the same write, so all ports see the same content (R1)
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic [FW-1:0] store [DEPTH];
    logic [FW-1:0] qA, qB;
    always_ff @(posedge clk) begin
      if (wrEn) store[wrAddr] <= wrData;
      qA <= store[rdAddr[(2*c)*AW +: AW]];
      qB <= store[rdAddr[(2*c+1)*AW +: AW]];
    end
    assign rdData[(2*c)*FW +: FW]   = qA;
    assign rdData[(2*c+1)*FW +: FW] = qB;
  end
endmodule

// File: rtl/pbo_sequencer.sv
module pbo_sequencer
  import pbo_pkg::*;
#(
  parameter int LANES = 3,
  parameter int AW    = 4,
  parameter int BW    = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] lastAddr,
  output seqStrobe_t    strobe,
  output logic [AW-1:0] anchor,
  output logic [BW-1:0] base,
  output logic [AW-1:0] lastQ,
  output logic          busy
);
  logic          running;
  logic [BW-1:0] rowEnd, lastWide, anchorNext;
  logic          endOfRow, lastStep;

  assign lastWide   = BW'(lastQ);
  assign anchorNext = BW'(anchor) + BW'(1);
  assign rowEnd     = base + BW'(LANES - 1);
  assign endOfRow   = rowEnd >= lastWide;
  assign lastStep   = endOfRow && (anchorNext >= lastWide);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      anchor  <= '0;
      base    <= '0;
      lastQ   <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        lastQ   <= lastAddr;
        anchor  <= '0;
        base    <= BW'(1);
      end
    end else if (lastStep) begin
      running <= 1'b0;
    end else if (endOfRow) begin
      anchor <= anchor + AW'(1);
      base   <= anchorNext + BW'(1);
    end else begin
      base <= base + BW'(LANES);
    end
  end

  assign strobe.issue  = running;
  assign strobe.finish = running & lastStep;
  assign busy          = running;

  // R2: a start during a pass neither ends it nor reloads the bound
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (running && !lastStep) |=> (running && lastQ == $past(lastQ)));

  // R4: the anchor never reaches the last box while issuing
  assert_anchor_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (running && lastQ != '0) |-> (BW'(anchor) < lastWide));

  // R4: partners always lie beyond the anchor
  assert_base_ahead_R4: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (base > BW'(anchor)));
endmodule

// File: rtl/pbo_datapath.sv
module pbo_datapath
  import pbo_pkg::*;
#(
  parameter int COPIES = 2,
  parameter int AW     = 4,
  parameter int BW     = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strobe,
  input  logic [AW-1:0]            anchor,
  input  logic [BW-1:0]            base,
  input  logic [AW-1:0]            lastQ,
  input  logic                     wrEn,
  input  logic [AW-1:0]            wrAddr,
  input  logic [2*AXES*FLT_W-1:0]  wrCoord,
  output logic [2*COPIES-2:0]      laneValid,
  output logic [2*COPIES-2:0]      laneHit,
  output logic [(2*COPIES-1)*AW-1:0] laneIdxI,
  output logic [(2*COPIES-1)*AW-1:0] laneIdxJ,
  output logic                     passDone
);
  localparam int PORTS = 2 * COPIES;
  localparam int LANES = PORTS - 1;
  localparam int MEMS  = 2 * AXES;

  logic [PORTS*AW-1:0]    rdAddr;
  logic [PORTS*FLT_W-1:0] rdData [MEMS];
  logic [LANES-1:0]       validQ;
  logic [AW-1:0]          idxIQ;
  logic [AW-1:0]          idxJQ [LANES];
  logic                   doneQ;

  // port 0 is the anchor, port p carries partner base+p-1
  always_comb begin
    rdAddr[0 +: AW] = anchor;
    for (int p = 1; p < PORTS; p++)
      rdAddr[p*AW +: AW] = AW'(base + BW'(p - 1));
  end

  // memory order: lowX, highX, lowY, highY, lowZ, highZ
  for (genvar m = 0; m < MEMS; m++) begin : g_mem
    pbo_coord_mem #(.COPIES(COPIES), .AW(AW), .FW(FLT_W)) u_mem (
      .clk    (clk),
      .wrEn   (wrEn),
      .wrAddr (wrAddr),
      .wrData (wrCoord[m*FLT_W +: FLT_W]),
      .rdAddr (rdAddr),
      .rdData (rdData[m])
    );
  end

  // index and validity pipeline aligned with the one-cycle RAM read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      doneQ  <= 1'b0;
      idxIQ  <= '0;
      for (int k = 0; k < LANES; k++) idxJQ[k] <= '0;
    end else begin
      doneQ <= strobe.finish;
      idxIQ <= anchor;
      for (int k = 0; k < LANES; k++) begin
        validQ[k] <= strobe.issue && ((base + BW'(k)) <= BW'(lastQ)); // R5
        idxJQ[k]  <= AW'(base + BW'(k));
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [AXES-1:0] axisOk;
    for (genvar a = 0; a < AXES; a++) begin : g_axis
      logic [FLT_W-1:0] aLo, aHi, pLo, pHi;
      assign aLo = rdData[2*a][0 +: FLT_W];
      assign aHi = rdData[2*a+1][0 +: FLT_W];
      assign pLo = rdData[2*a][(k+1)*FLT_W +: FLT_W];
      assign pHi = rdData[2*a+1][(k+1)*FLT_W +: FLT_W];
      // R7: inclusive interval test on one axis
      assign axisOk[a] = fltGe(aHi, pLo) && fltGe(pHi, aLo);
    end
    assign laneValid[k]            = validQ[k];
    assign laneHit[k]              = validQ[k] & (&axisOk);
    assign laneIdxI[k*AW +: AW]    = idxIQ;
    assign laneIdxJ[k*AW +: AW]    = idxJQ[k];

    // R6: a reported pair is always ordered
    assert_pair_order_R6: assert property (@(posedge clk) disable iff (!rstN)
      laneValid[k] |-> (idxIQ < idxJQ[k]));

    if (k > 0) begin : g_prefix
      // R5: valid lanes form a prefix
      assert_lane_prefix_R5: assert property (@(posedge clk) disable iff (!rstN)
        laneValid[k] |-> laneValid[k-1]);
    end
  end

  assign passDone = doneQ;

  // R9: the end-of-pass marker lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    passDone |=> !passDone);
endmodule

// File: rtl/pair_overlap_cmp.sv
module pair_overlap_cmp
  import pbo_pkg::*;
#(
  parameter int COPIES    = 2,
  parameter int MAX_BOXES = 16,
  parameter int AW        = $clog2(MAX_BOXES),
  parameter int LANES     = 2 * COPIES - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [AW-1:0]       wrAddr,
  input  logic [31:0]         wrMinX,
  input  logic [31:0]         wrMaxX,
  input  logic [31:0]         wrMinY,
  input  logic [31:0]         wrMaxY,
  input  logic [31:0]         wrMinZ,
  input  logic [31:0]         wrMaxZ,
  input  logic                start,
  input  logic [AW-1:0]       lastAddr,
  output logic [LANES-1:0]    laneValid,
  output logic [LANES-1:0]    laneHit,
  output logic [LANES*AW-1:0] laneIdxI,
  output logic [LANES*AW-1:0] laneIdxJ,
  output logic                passDone,
  output logic                busy
);
  localparam int BW = AW + $clog2(2 * COPIES) + 1;

  seqStrobe_t    strobe;
  logic [AW-1:0] anchor, lastQ;
  logic [BW-1:0] base;

  pbo_sequencer #(.LANES(LANES), .AW(AW), .BW(BW)) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lastAddr (lastAddr),
    .strobe   (strobe),
    .anchor   (anchor),
    .base     (base),
    .lastQ    (lastQ),
    .busy     (busy)
  );

  pbo_datapath #(.COPIES(COPIES), .AW(AW), .BW(BW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .anchor    (anchor),
    .base      (base),
    .lastQ     (lastQ),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrCoord   ({wrMaxZ, wrMinZ, wrMaxY, wrMinY, wrMaxX, wrMinX}),
    .laneValid (laneValid),
    .laneHit   (laneHit),
    .laneIdxI  (laneIdxI),
    .laneIdxJ  (laneIdxJ),
    .passDone  (passDone)
  );
endmodule

// File: tb/pair_overlap_cmp_tb.sv
module pair_overlap_cmp_tb_top;
  localparam int COPIES = 2;
  localparam int NB     = 16;
  localparam int AW     = 4;
  localparam int LANES  = 2 * COPIES - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [31:0] wrMinX = '0, wrMaxX = '0, wrMinY = '0, wrMaxY = '0, wrMinZ = '0, wrMaxZ = '0;
  logic start = 1'b0;
  logic [AW-1:0] lastAddr = '0;
  logic [LANES-1:0] laneValid, laneHit;
  logic [LANES*AW-1:0] laneIdxI, laneIdxJ;
  logic passDone, busy;

  int total = 0;
  int bad = 0;

  // integer model of the boxes: [axis][box]
  int lo [3][NB];
  int hi [3][NB];
  logic [31:0] loBits [3][NB];
  logic [31:0] hiBits [3][NB];
  int seen [NB][NB];

  always #2.5 clk = ~clk;

  pair_overlap_cmp #(.COPIES(COPIES), .MAX_BOXES(NB)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrMinX(wrMinX), .wrMaxX(wrMaxX), .wrMinY(wrMinY), .wrMaxY(wrMaxY),
    .wrMinZ(wrMinZ), .wrMaxZ(wrMaxZ), .start(start), .lastAddr(lastAddr),
    .laneValid(laneValid), .laneHit(laneHit), .laneIdxI(laneIdxI),
    .laneIdxJ(laneIdxJ), .passDone(passDone), .busy(busy)
  );

  function automatic logic [31:0] toF(int v);
    int mag, msb;
    logic [31:0] r;
    if (v == 0) return 32'h0;
    mag = (v < 0) ? -v : v;
    msb = 0;
    for (int b = 0; b < 24; b++) if (mag[b]) msb = b;
    r[31]    = (v < 0);
    r[30:23] = 8'(127 + msb);
    r[22:0]  = 23'((mag << (23 - msb)) & 32'h7F_FFFF);
    return r;
  endfunction

  function automatic int expectT(int l);
    int t;
    if (l == 0) return 1;
    t = 0;
    for (int r = 1; r <= l; r++) t += (r + LANES - 1) / LANES;
    return t;
  endfunction

  function automatic bit overlap(int i, int j);
    bit ok;
    ok = 1'b1;
    for (int a = 0; a < 3; a++)
      if (!(hi[a][i] >= lo[a][j] && lo[a][i] <= hi[a][j])) ok = 1'b0;
    return ok;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic buildPattern(int pat);
    for (int i = 0; i < NB; i++) begin
      for (int a = 0; a < 3; a++) begin
        int c, h;
        case (pat)
          0: begin c = ((i * (5 + 2*a)) % 11) - 5; h = 1 + ((i + a) % 2); end
          1: begin c = (((i * (3 + a)) % 9) - 4) * 37; h = 20 + 25 * ((i + a) % 3); end
          2: begin c = (a == 0) ? 2 * i + 1 : 0; h = 1; end
          default: begin c = 1000000; h = 3; end
        endcase
        lo[a][i] = c - h;
        hi[a][i] = c + h;
        loBits[a][i] = toF(lo[a][i]);
        hiBits[a][i] = toF(hi[a][i]);
      end
    end
    if (pat == 2) begin
      // box 0 y in [-1, -0], box 1 y in [+0, 1]: contact at zero (R8)
      hi[1][0] = 0; hiBits[1][0] = 32'h8000_0000;
      lo[1][1] = 0; loBits[1][1] = 32'h0000_0000;
    end
  endtask

  task automatic loadAll();
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = AW'(i);
      wrMinX = loBits[0][i]; wrMaxX = hiBits[0][i];
      wrMinY = loBits[1][i]; wrMaxY = hiBits[1][i];
      wrMinZ = loBits[2][i]; wrMaxZ = hiBits[2][i];
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runPass(int l, bit glitch, int pat);
    int t, k, doneAt, hitsSeen, hitsExp, prevI, prevJ0;
    bit busyOk, quietOk, covOk, anyValid;
    t = expectT(l);
    for (int i = 0; i < NB; i++) for (int j = 0; j < NB; j++) seen[i][j] = 0;
    doneAt = -1; hitsSeen = 0; busyOk = 1'b1; quietOk = 1'b1; anyValid = 1'b0;
    prevI = -1; prevJ0 = -1;
    @(negedge clk);
    start = 1'b1; lastAddr = AW'(l);
    k = 0;
    while (doneAt < 0 && k < t + 6) begin
      @(negedge clk);
      k++;
      start = (glitch && k == 3) ? 1'b1 : 1'b0;
      if (k <= t && busy !== 1'b1) busyOk = 1'b0;
      if (k == t + 1 && busy !== 1'b0) busyOk = 1'b0;
      for (int ln = 0; ln < LANES; ln++) begin
        int ii, jj;
        ii = int'(laneIdxI[ln*AW +: AW]);
        jj = int'(laneIdxJ[ln*AW +: AW]);
        if (laneValid[ln]) begin
          anyValid = 1'b1;
          check(ii < jj && jj <= l, "R6 pair range", jj, l);
          if (ii < jj && jj <= l) begin
            seen[ii][jj]++;
            check(laneHit[ln] == overlap(ii, jj), "R7 overlap result", int'(laneHit[ln]), int'(overlap(ii, jj)));
            if (laneHit[ln]) hitsSeen++;
            if (pat == 2 && ii == 0 && jj == 1)
              check(laneHit[ln] == 1'b1, "R8 negative zero contact", int'(laneHit[ln]), 1);
          end
        end else if (laneHit[ln]) quietOk = 1'b0;
      end
      if (l >= 1 && k >= 2 && k <= t + 1) begin
        int i0, j0;
        i0 = int'(laneIdxI[0 +: AW]);
        j0 = int'(laneIdxJ[0 +: AW]);
        check(laneValid[0] == 1'b1, "R4 lane0 live", int'(laneValid[0]), 1);
        if (k == 2) begin
          for (int ln = 0; ln < LANES; ln++)
            if (ln + 1 <= l)
              check(int'(laneIdxJ[ln*AW +: AW]) == ln + 1 && int'(laneIdxI[ln*AW +: AW]) == 0,
                    "R3 first group", int'(laneIdxJ[ln*AW +: AW]), ln + 1);
        end else if (i0 == prevI) begin
          check(j0 == prevJ0 + LANES, "R4 partner stride", j0, prevJ0 + LANES);
        end else begin
          check(i0 == prevI + 1 && j0 == i0 + 1, "R4 row switch", j0, prevI + 2);
        end
        prevI = i0; prevJ0 = j0;
      end
      if (passDone) doneAt = k;
    end
    check(doneAt == t + 1, glitch ? "R2 start ignored, pass length" : "R9 done timing", doneAt, t + 1);
    check(busyOk, "R2 busy window", int'(busyOk), 1);
    check(quietOk, "R5 masked lanes quiet", int'(quietOk), 1);
    covOk = 1'b1; hitsExp = 0;
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NB; j++) begin
        int want;
        want = (i < j && j <= l) ? 1 : 0;
        if (seen[i][j] != want) covOk = 1'b0;
        if (want == 1 && overlap(i, j)) hitsExp++;
      end
    check(covOk, "R6 every pair once", int'(covOk), 1);
    check(hitsSeen == hitsExp, "R1 hits from stored data", hitsSeen, hitsExp);
    if (l == 0) check(!anyValid, "R9 single box no lanes", int'(anyValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(laneValid == '0 && laneHit == '0 && passDone == 1'b0 && busy == 1'b0,
          "R10 reset state", int'(laneValid), 0);
    rstN = 1'b1;
    for (int pat = 0; pat < 4; pat++) begin
      buildPattern(pat);
      loadAll();
      for (int l = 0; l < NB; l++)
        runPass(l, (pat == 1 && expectT(l) >= 5), pat);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule